// File: doc/BRIEF.md
# Multi-Scheme Tag Load-Modulation Encoder

This block turns the serial bit stream of a passive tag into the on/off control of the tag's switchable damping load. The load switch itself and the bit-rate timing live elsewhere. Per-bit timing comes in as two single-cycle strobes, one at each bit boundary and one at the middle of each bit. The block runs on the recovered carrier clock, so every count below is in carrier cycles.

A mode input selects one of ten encodings:

- direct NRZ;
- four frequency-shift variants, whose carrier divisors of 5, 8 and 10 are paired asymmetrically;
- three phase-shift variants, each with its own rule for flipping the subcarrier phase;
- Manchester;
- bi-phase.

An invert option complements each data bit before it is encoded.

Each data bit is captured on the clock edge where the boundary strobe is high. From that edge the encoded waveform for the bit appears on `damp`, decoded combinationally from a small set of registers.

Top module: `tag_load_encoder`

## Requirements
- R1: Mode 0 (NRZ): after the edge that samples `bit_start`, `damp` equals the captured bit (1 = damping on) until the next boundary.
- R2: With `invert` high, the bit captured at a boundary is the complement of `data_in`, and every mode encodes that complemented bit.
- R3: Modes 1 and 2 send a 0 bit as a square wave of period 8 cycles. A 1 bit has period 5 cycles in mode 1 and period 10 cycles in mode 2.
- R4: Modes 3 and 4 send a 1 bit with period 8. A 0 bit has period 5 cycles in mode 3 and period 10 cycles in mode 4.
- R5: A frequency-shift wave of period d is high for the first floor(d/2) cycles of each period. Cycle 0 is the first cycle after a boundary edge; the period count restarts at every boundary, even when the bit length is not a multiple of d.
- R6: In modes 5 to 7, `damp` is a subcarrier XOR a phase bit. The subcarrier restarts at each boundary, is high in the first half of its period, and has period 2, 4 or 8 cycles for `sc_sel` = 0, 1 or 2–3.
- R7: Mode 5 inverts the phase bit at a boundary whose new bit differs from the previous bit.
- R8: Mode 6 inverts the phase bit at every boundary whose new bit is 1.
- R9: Mode 7 inverts the phase bit only at a boundary where the bit goes from 0 to 1.
- R10: Mode 8 (Manchester): `damp` is the complement of the bit before the mid-bit strobe and the bit itself after it. A 1 is thus a rising mid-bit transition and a 0 a falling one.
- R11: Mode 9 (bi-phase): `damp` toggles at every boundary and toggles again at the mid-bit strobe of a 1 bit.
- R12: After reset, the previous bit, phase and bi-phase level are 0. Mode codes 10 to 15 hold `damp` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_start | input | 1 | One-cycle strobe at each bit boundary |
| mid_bit | input | 1 | One-cycle strobe at the middle of each bit |
| data_in | input | 1 | Data bit, sampled with `bit_start` |
| mode | input | 4 | Encoding select (codes 0–9, see requirements) |
| sc_sel | input | 2 | Phase-shift subcarrier select |
| invert | input | 1 | Complement data before encoding |
| damp | output | 1 | Damping-load enable |

## Verification
The assertions assume the following about the inputs:

- `bit_start` and `mid_bit` never pulse in the same cycle.
- `mode`, `sc_sel` and `invert` change only while reset is applied.
- The phase-shift bit length is a multiple of the subcarrier period.

The stimulus meets all three. Each configuration runs from its own reset, and strobes come from a per-bit cycle counter, with the mid-bit strobe at half the bit length. Phase-shift runs use a bit length of 40 cycles. Frequency-shift runs use 36 cycles, which is not a multiple of 5, 8 or 10, so the restart of the period count at each boundary is visible.

// File: rtl/tag_load_encoder.sv
module tag_load_encoder #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_start,
  input  logic             mid_bit,
  input  logic             data_in,
  input  logic [3:0]       mode,
  input  logic [1:0]       sc_sel,
  input  logic             invert,
  output logic             damp
);

  localparam logic [3:0] M_NRZ   = 4'd0;
  localparam logic [3:0] M_FSK1A = 4'd1;
  localparam logic [3:0] M_FSK2A = 4'd2;
  localparam logic [3:0] M_FSK1  = 4'd3;
  localparam logic [3:0] M_FSK2  = 4'd4;
  localparam logic [3:0] M_PSK1  = 4'd5;
  localparam logic [3:0] M_PSK2  = 4'd6;
  localparam logic [3:0] M_PSK3  = 4'd7;
  localparam logic [3:0] M_MAN   = 4'd8;
  localparam logic [3:0] M_BI    = 4'd9;

  localparam logic [CNT_W-1:0] P1  = CNT_W'(1);
  localparam logic [CNT_W-1:0] P2  = CNT_W'(2);
  localparam logic [CNT_W-1:0] P4  = CNT_W'(4);
  localparam logic [CNT_W-1:0] P5  = CNT_W'(5);
  localparam logic [CNT_W-1:0] P8  = CNT_W'(8);
  localparam logic [CNT_W-1:0] P10 = CNT_W'(10);

  logic             nbit;
  logic             cur_q, ph_q, lvl_q, late_q;
  logic [CNT_W-1:0] cnt_q, per_len, sc_len;
  logic             wave, flip;

  assign nbit = data_in ^ invert;

  always_comb begin
    case (sc_sel)
      2'd0:    sc_len = P2;
      2'd1:    sc_len = P4;
      default: sc_len = P8;
    endcase
  end

  always_comb begin
    case (mode)
      M_FSK1A: per_len = cur_q ? P5  : P8;
      M_FSK2A: per_len = cur_q ? P10 : P8;
      M_FSK1:  per_len = cur_q ? P8  : P5;
      M_FSK2:  per_len = cur_q ? P8  : P10;
      M_PSK1, M_PSK2, M_PSK3: per_len = sc_len;
      default: per_len = P1;
    endcase
  end

  always_comb begin
    case (mode)
      M_PSK1:  flip = nbit ^ cur_q;
      M_PSK2:  flip = nbit;
      M_PSK3:  flip = nbit & ~cur_q;
      default: flip = 1'b0;
    endcase
  end

  assign wave = cnt_q < (per_len >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (bit_start)            cnt_q <= '0;
    else if (cnt_q >= per_len - P1) cnt_q <= '0;
    else                           cnt_q <= cnt_q + P1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      ph_q   <= 1'b0;
      lvl_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (bit_start) begin
      cur_q  <= nbit;
      ph_q   <= ph_q ^ flip;
      lvl_q  <= ~lvl_q;
      late_q <= 1'b0;
    end else if (mid_bit) begin
      lvl_q  <= lvl_q ^ cur_q;
      late_q <= 1'b1;
    end
  end

  always_comb begin
    case (mode)
      M_NRZ:                          damp = cur_q;
      M_FSK1A, M_FSK2A, M_FSK1, M_FSK2: damp = wave;
      M_PSK1, M_PSK2, M_PSK3:         damp = wave ^ ph_q;
      M_MAN:                          damp = late_q ? cur_q : ~cur_q;
      M_BI:                           damp = lvl_q;
      default:                        damp = 1'b0;
    endcase
  end

  assert_nrz_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && mode == M_NRZ) |=> (mode != M_NRZ || damp == $past(data_in ^ invert)));

  assert_psk3_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && mode == M_PSK3 && !(data_in ^ invert)) |=> $stable(ph_q));

  assert_psk3_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && mode == M_PSK3 && (data_in ^ invert) && !cur_q) |=> (ph_q != $past(ph_q)));

  assert_man_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_bit && !bit_start && mode == M_MAN) |=> (mode != M_MAN || damp != $past(damp)));

  assert_bi_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && mode == M_BI) |=> (mode != M_BI || damp != $past(damp)));

  assert_unused_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > M_BI) |-> !damp);

endmodule

// File: tb/sim_tag_load_encoder.sv
module sim_tag_load_encoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_start = 1'b0, mid_bit = 1'b0;
  logic data_in = 1'b0, invert = 1'b0, damp;
  logic [3:0] mode = 4'd0;
  logic [1:0] sc_sel = 2'd0;

  int checks = 0, errors = 0;
  bit m_cur, m_ph, m_lvl, m_half;
  int m_pos;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_load_encoder u0 (
    .clk(clk), .rst_n(rst_n), .bit_start(bit_start), .mid_bit(mid_bit),
    .data_in(data_in), .mode(mode), .sc_sel(sc_sel), .invert(invert), .damp(damp)
  );

  function automatic int fsk_period(input logic [3:0] md, input bit b);
    case (md)
      4'd1: return b ? 5 : 8;
      4'd2: return b ? 10 : 8;
      4'd3: return b ? 8 : 5;
      default: return b ? 8 : 10;
    endcase
  endfunction

  function automatic bit expect_damp();
    int d;
    case (mode)
      4'd0: return m_cur;
      4'd1, 4'd2, 4'd3, 4'd4: begin
        d = fsk_period(mode, m_cur);
        return (m_pos % d) < (d / 2);
      end
      4'd5, 4'd6, 4'd7: begin
        d = (sc_sel == 2'd0) ? 2 : (sc_sel == 2'd1) ? 4 : 8;
        return ((m_pos % d) < (d / 2)) ^ m_ph;
      end
      4'd8: return m_half ? m_cur : !m_cur;
      4'd9: return m_lvl;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_name();
    string s;
    case (mode)
      4'd0: s = "R1";
      4'd1, 4'd2: s = "R3 R5";
      4'd3, 4'd4: s = "R4 R5";
      4'd5: s = "R7 R6";
      4'd6: s = "R8 R6";
      4'd7: s = "R9 R6";
      4'd8: s = "R10";
      4'd9: s = "R11";
      default: s = "R12";
    endcase
    if (invert) s = {s, " R2"};
    return s;
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (damp !== exp) begin
      errors++;
      $display("FAIL %s: damp=%b expected %b (mode %0d sel %0d inv %0d pos %0d)",
               req, damp, exp, mode, sc_sel, invert, m_pos);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_start = 1'b0; mid_bit = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cur = 0; m_ph = 0; m_lvl = 0; m_half = 0; m_pos = 0;
  endtask

  task automatic run(input logic [3:0] md, input logic [1:0] sel, input bit inv,
                     input int blen, input logic [15:0] pat);
    bit n, fl;
    mode = md; sc_sel = sel; invert = inv;
    do_reset();
    check("R12", expect_damp());
    for (int b = 0; b < 16; b++) begin
      for (int j = 0; j < blen; j++) begin
        data_in = pat[b];
        bit_start = (j == 0);
        mid_bit = (j == blen / 2);
        n = pat[b] ^ inv;
        if (bit_start) begin
          case (md)
            4'd5: fl = (n != m_cur);
            4'd6: fl = n;
            4'd7: fl = n && !m_cur;
            default: fl = 0;
          endcase
          m_ph ^= fl;
          m_lvl ^= 1'b1;
          m_cur = n;
          m_half = 0;
          m_pos = 0;
        end else begin
          m_pos++;
          if (mid_bit) begin
            m_half = 1;
            m_lvl ^= m_cur;
          end
        end
        @(negedge clk);
        check(req_name(), expect_damp());
      end
    end
    bit_start = 1'b0; mid_bit = 1'b0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R12", 1'b0);
    for (int md = 0; md < 12; md++)
      for (int inv = 0; inv < 2; inv++)
        for (int sel = 0; sel < 4; sel++) begin
          if (sel > 0 && !(md >= 5 && md <= 7)) continue;
          run(4'(md), 2'(sel), bit'(inv), (md >= 1 && md <= 4) ? 36 : 40, 16'b1011_0010_0111_0100);
          if (md <= 9 && sel == 0)
            run(4'(md), 2'(sel), bit'(inv), (md >= 1 && md <= 4) ? 36 : 40, 16'b0100_1101_1000_1111);
        end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule